// File: doc/BRIEF.md
# Asynchronous Completion Signal Tracker

Each wave that launches global memory reads and writes without waiting for them needs a small scoreboard. This block provides one. It holds sixteen completion slots, and each slot has a 4-bit id. A memory operation that is launched claims one slot by id, and that slot becomes pending. The wave keeps running after the launch. Later, the memory side reports the finished slot id, and that slot reads as done again. A slot that has never been used also reads as done.

The wave asks about slots through a query port. A check operation on one or two slots returns a scalar answer in the same cycle and never holds the wave. A wait operation on one, two, three or four slots raises the stall output until every slot it lists has completed. In the cycle that the last listed slot completes, the stall drops and the result is given as 1. A launch that names a slot which is still pending also raises the stall, so the tracking of that slot is never overwritten.

Top module: `sig_tracker`

## Requirements
- R1: After reset every slot reads as done, and `stall` is low while no port is active.
- R2: A launch that is accepted makes its slot pending from the next cycle on. A one-slot check on that slot then returns 0.
- R3: A completion sets its slot back to done from the next cycle on. A query in the same cycle as the completion already sees that slot as done.
- R4: Op code 0 is a one-slot check on the id in `q_slots[3:0]`. It never stalls, it always gives a valid result of 0 or 1, and the other id fields have no effect on it.
- R5: Op code 1 is a two-slot check on the ids in `q_slots[3:0]` and `q_slots[7:4]`. It returns 1 only when both slots are done, and 0 otherwise.
- R6: Op code 2 waits on the slot in `q_slots[3:0]`. While that slot is pending, `stall` is high and `q_res_valid` is low.
- R7: Op codes 3, 4 and 5 wait on all of the first 2, 3 or 4 id fields respectively, where field k is `q_slots[4k+3:4k]`. The fields past that count have no effect.
- R8: A wait is released in the same cycle that its last pending slot completes. In that cycle `stall` is low, `q_res_valid` is high and `q_res` equals 1.
- R9: A launch to a slot that is still pending raises `stall`, and that slot stays pending. If a completion for the same slot arrives in the same cycle, the launch is accepted instead, and the slot is pending again afterwards.
- R10: A query in the same cycle as a launch sees the slot states from before the launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | A launch claims a slot this cycle |
| iss_slot | input | 4 | Slot id claimed by the launch |
| cpl_valid | input | 1 | The memory side reports a completion |
| cpl_slot | input | 4 | Slot id that completed |
| q_valid | input | 1 | A query is presented |
| q_op | input | 3 | Query op code: 0/1 check one or two slots, 2 wait one slot, 3/4/5 wait on all of 2/3/4 slots |
| q_slots | input | 16 | Four packed slot ids; field k is bits 4k+3:4k |
| q_res_valid | output | 1 | The query result is valid this cycle |
| q_res | output | 32 | Scalar result, zero-extended 0 or 1 |
| stall | output | 1 | Hold the wave: a wait is unsatisfied or the launched slot is busy |

## Verification
If a slot's pending bit is wrong, the error shows up on the first query that names that slot. A check returns the wrong scalar in that same cycle. A wait shows the error as a missing stall, or as a stall that stays up after the completion has arrived. A launch that should have been held shows it at once on `stall`. A completion that was dropped shows it as a wait that never releases. The stimulus builds up a known pattern of pending slots through launches and completions, then reads that pattern back with checks and waits. It compares each of them in the cycle the query is presented.

// File: rtl/sig_tracker_pkg.sv
package sig_tracker_pkg;

    localparam int DEF_SLOTS = 16;
    localparam int DEF_LIST  = 4;
    localparam int DEF_RES_W = 32;

    typedef enum logic [2:0] {
        OP_DONE1    = 3'd0,
        OP_DONE2    = 3'd1,
        OP_WAIT1    = 3'd2,
        OP_WAITALL2 = 3'd3,
        OP_WAITALL3 = 3'd4,
        OP_WAITALL4 = 3'd5
    } op_e;

    typedef struct packed {
        logic       blocking;
        logic [2:0] count;
    } op_info_t;

    // Unknown codes behave as a one-slot check.
    function automatic op_info_t decode_op(logic [2:0] code);
        op_info_t info;
        case (op_e'(code))
            OP_DONE2:    info = '{blocking: 1'b0, count: 3'd2};
            OP_WAIT1:    info = '{blocking: 1'b1, count: 3'd1};
            OP_WAITALL2: info = '{blocking: 1'b1, count: 3'd2};
            OP_WAITALL3: info = '{blocking: 1'b1, count: 3'd3};
            OP_WAITALL4: info = '{blocking: 1'b1, count: 3'd4};
            default:     info = '{blocking: 1'b0, count: 3'd1};
        endcase
        return info;
    endfunction

endpackage

// File: rtl/sig_tracker_slots.sv
module sig_tracker_slots #(
    parameter int NUM_SLOTS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_SLOTS-1:0] set_vec,
    input  logic [NUM_SLOTS-1:0] clr_vec,
    output logic [NUM_SLOTS-1:0] pend
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                pend[s] <= 1'b0;
            else if (set_vec[s])
                pend[s] <= 1'b1;
            else if (clr_vec[s])
                pend[s] <= 1'b0;
        end
    end

endmodule

// File: rtl/sig_tracker_query.sv
module sig_tracker_query
    import sig_tracker_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int LIST_MAX  = 4,
    localparam int ID_W     = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0]     done_vec,
    input  logic [2:0]               op_code,
    input  logic [LIST_MAX*ID_W-1:0] slot_list,
    output logic                     all_done,
    output logic                     blocking
);

    op_info_t            info;
    logic [LIST_MAX-1:0] field_ok;

    assign info     = decode_op(op_code);
    assign blocking = info.blocking;

    for (genvar k = 0; k < LIST_MAX; k++) begin : g_field
        logic [ID_W-1:0] id;
        assign id          = slot_list[k*ID_W +: ID_W];
        assign field_ok[k] = (k >= int'(info.count)) || done_vec[id];
    end

    assign all_done = &field_ok;

endmodule

// File: rtl/sig_tracker.sv
module sig_tracker
    import sig_tracker_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int LIST_MAX  = DEF_LIST,
    parameter int RES_W     = DEF_RES_W,
    localparam int ID_W     = $clog2(NUM_SLOTS)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     iss_valid,
    input  logic [ID_W-1:0]          iss_slot,
    input  logic                     cpl_valid,
    input  logic [ID_W-1:0]          cpl_slot,
    input  logic                     q_valid,
    input  logic [2:0]               q_op,
    input  logic [LIST_MAX*ID_W-1:0] q_slots,
    output logic                     q_res_valid,
    output logic [RES_W-1:0]         q_res,
    output logic                     stall
);

    logic [NUM_SLOTS-1:0] pend;
    logic [NUM_SLOTS-1:0] cpl_hot;
    logic [NUM_SLOTS-1:0] iss_hot;
    logic [NUM_SLOTS-1:0] done_now;
    logic                 iss_block;
    logic                 wait_block;
    logic                 all_done;
    logic                 blocking;

    // A completion is visible in its own cycle.
    assign cpl_hot  = cpl_valid ? (NUM_SLOTS'(1) << cpl_slot) : '0;
    assign done_now = ~pend | cpl_hot;

    assign iss_block = iss_valid && !done_now[iss_slot];
    assign iss_hot   = (iss_valid && !iss_block) ? (NUM_SLOTS'(1) << iss_slot) : '0;

    sig_tracker_slots #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk     (clk),
        .rst     (rst),
        .set_vec (iss_hot),
        .clr_vec (cpl_hot),
        .pend    (pend)
    );

    sig_tracker_query #(.NUM_SLOTS(NUM_SLOTS), .LIST_MAX(LIST_MAX)) u_query (
        .done_vec  (done_now),
        .op_code   (q_op),
        .slot_list (q_slots),
        .all_done  (all_done),
        .blocking  (blocking)
    );

    assign wait_block  = q_valid && blocking && !all_done;
    assign stall       = iss_block || wait_block;
    assign q_res_valid = q_valid && !wait_block;
    assign q_res       = RES_W'(all_done);

endmodule

// File: rtl/sig_tracker_chk.sv
module sig_tracker_chk #(
    parameter int NUM_SLOTS = 16,
    parameter int RES_W     = 32,
    localparam int ID_W     = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 iss_valid,
    input logic [ID_W-1:0]      iss_slot,
    input logic                 cpl_valid,
    input logic [ID_W-1:0]      cpl_slot,
    input logic                 q_valid,
    input logic [2:0]           q_op,
    input logic                 q_res_valid,
    input logic [RES_W-1:0]     q_res,
    input logic                 stall,
    input logic [NUM_SLOTS-1:0] pend
);

    logic same_slot;
    assign same_slot = cpl_valid && (cpl_slot == iss_slot);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pend == '0));

    p_issue_pending_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && (!pend[iss_slot] || same_slot)) |=> pend[$past(iss_slot)]);

    p_cpl_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && !(iss_valid && same_slot)) |=> !pend[$past(cpl_slot)]);

    p_check_no_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (q_valid && (q_op <= 3'd1)) |-> q_res_valid);

    p_release_one_r8: assert property (@(posedge clk) disable iff (rst)
        (q_valid && (q_op >= 3'd2) && (q_op <= 3'd5) && q_res_valid) |-> (q_res == RES_W'(1)));

    p_busy_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && pend[iss_slot] && !same_slot) |-> stall);

    p_busy_held_r9: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && pend[iss_slot] && !same_slot) |=> pend[$past(iss_slot)]);

endmodule

bind sig_tracker sig_tracker_chk #(.NUM_SLOTS(NUM_SLOTS), .RES_W(RES_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .iss_valid   (iss_valid),
    .iss_slot    (iss_slot),
    .cpl_valid   (cpl_valid),
    .cpl_slot    (cpl_slot),
    .q_valid     (q_valid),
    .q_op        (q_op),
    .q_res_valid (q_res_valid),
    .q_res       (q_res),
    .stall       (stall),
    .pend        (pend)
);

// File: tb/sig_tracker_tb.sv
module sig_tracker_tb;

    typedef struct packed {
        logic        iv;
        logic [3:0]  iid;
        logic        cv;
        logic [3:0]  cid;
        logic        qv;
        logic [2:0]  op;
        logic [15:0] sl;
        logic        st;
        logic        rv;
        logic        res;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd0, 16'h0003, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'd3,  1'b0, 4'd0,  1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd0, 16'h0003, 1'b0, 1'b1, 1'b0},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd0, 16'h3334, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'd5,  1'b0, 4'd0,  1'b1, 3'd0, 16'h0005, 1'b0, 1'b1, 1'b1},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd1, 16'h0043, 1'b0, 1'b1, 1'b0},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd1, 16'h0064, 1'b0, 1'b1, 1'b1},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd2, 16'h0003, 1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b1, 4'd3,  1'b1, 3'd2, 16'h0003, 1'b0, 1'b1, 1'b1},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd0, 16'h0003, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'd7,  1'b0, 4'd0,  1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd3, 16'h0075, 1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b1, 4'd5,  1'b1, 3'd3, 16'h0075, 1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b1, 4'd7,  1'b1, 3'd3, 16'h0075, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'd9,  1'b0, 4'd0,  1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b1, 4'd10, 1'b0, 4'd0,  1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd4, 16'h0BA9, 1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b1, 4'd10, 1'b1, 3'd4, 16'h0BA9, 1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b1, 4'd9,  1'b1, 3'd4, 16'h0BA9, 1'b0, 1'b1, 1'b1},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd5, 16'h3210, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'd12, 1'b0, 4'd0,  1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd5, 16'h321C, 1'b1, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b1, 4'd12, 1'b1, 3'd5, 16'h321C, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'd13, 1'b0, 4'd0,  1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd4, 16'hD210, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'd13, 1'b0, 4'd0,  1'b0, 3'd0, 16'h0000, 1'b1, 1'b0, 1'b0},
        '{1'b1, 4'd13, 1'b1, 4'd13, 1'b0, 3'd0, 16'h0000, 1'b0, 1'b0, 1'b0},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd0, 16'h000D, 1'b0, 1'b1, 1'b0},
        '{1'b0, 4'd0,  1'b1, 4'd13, 1'b1, 3'd0, 16'h000D, 1'b0, 1'b1, 1'b1},
        '{1'b1, 4'd2,  1'b0, 4'd0,  1'b1, 3'd2, 16'h0002, 1'b0, 1'b1, 1'b1},
        '{1'b0, 4'd0,  1'b0, 4'd0,  1'b1, 3'd0, 16'h0002, 1'b0, 1'b1, 1'b0}
    };

    function automatic string tag_of(int i);
        case (i)
            0:                   return "R1";
            1, 2:                return "R2";
            3:                   return "R4";
            4, 29, 30:           return "R10";
            5, 6:                return "R5";
            7:                   return "R6";
            8:                   return "R8";
            9, 28:               return "R3";
            22, 18, 13:          return "R8";
            25, 26, 27:          return "R9";
            default:             return "R7";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        iss_valid = 1'b0;
    logic [3:0]  iss_slot = '0;
    logic        cpl_valid = 1'b0;
    logic [3:0]  cpl_slot = '0;
    logic        q_valid = 1'b0;
    logic [2:0]  q_op = '0;
    logic [15:0] q_slots = '0;
    logic        q_res_valid;
    logic [31:0] q_res;
    logic        stall;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sig_tracker u_dut (
        .clk         (clk),
        .rst         (rst),
        .iss_valid   (iss_valid),
        .iss_slot    (iss_slot),
        .cpl_valid   (cpl_valid),
        .cpl_slot    (cpl_slot),
        .q_valid     (q_valid),
        .q_op        (q_op),
        .q_slots     (q_slots),
        .q_res_valid (q_res_valid),
        .q_res       (q_res),
        .stall       (stall)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        iss_valid = 1'b0; cpl_valid = 1'b0; q_valid = 1'b0;
        iss_slot = '0; cpl_slot = '0; q_op = '0; q_slots = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        chk("R1", "stall after reset", 32'(stall), 32'd0);
        chk("R1", "valid after reset", 32'(q_res_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            iss_valid = TBL[i].iv; iss_slot = TBL[i].iid;
            cpl_valid = TBL[i].cv; cpl_slot = TBL[i].cid;
            q_valid   = TBL[i].qv; q_op     = TBL[i].op; q_slots = TBL[i].sl;
            #2;
            chk(tag_of(i), $sformatf("stall v%0d", i), 32'(stall), 32'(TBL[i].st));
            chk(tag_of(i), $sformatf("valid v%0d", i), 32'(q_res_valid), 32'(TBL[i].rv));
            if (TBL[i].rv)
                chk(tag_of(i), $sformatf("result v%0d", i), q_res, 32'(TBL[i].res));
        end

        // R1: reset clears a pending slot (slot 2 pending at this point)
        @(negedge clk);
        idle();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        q_valid = 1'b1; q_op = 3'd2; q_slots = 16'h0002;
        #2;
        chk("R1", "wait after reset stall", 32'(stall), 32'd0);
        chk("R1", "wait after reset result", q_res, 32'd1);

        // R6: a wait holds across several cycles without completion
        @(negedge clk);
        idle();
        iss_valid = 1'b1; iss_slot = 4'd15;
        @(negedge clk);
        idle();
        q_valid = 1'b1; q_op = 3'd2; q_slots = 16'h000F;
        for (int c = 0; c < 3; c++) begin
            #2;
            chk("R6", "held wait stall", 32'(stall), 32'd1);
            @(negedge clk);
        end
        cpl_valid = 1'b1; cpl_slot = 4'd15;
        #2;
        chk("R8", "late release result", q_res, 32'd1);
        chk("R8", "late release stall", 32'(stall), 32'd0);

        @(negedge clk);
        idle();
        #2;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule